// File: doc/BRIEF.md
# Disk Arm Request Scheduler

This block keeps a small table of outstanding track requests for a disk arm. Each time the arm signals that it is free, the block picks the next request from the table under one of four run-time policies: arrival order, nearest track, a bidirectional elevator sweep, or a one-way sweep that wraps back to the lowest pending track. It then returns the chosen request's tag and track together with the arm's direction of travel.

Requests enter through an enqueue port that carries a track number and a tag. The head track is supplied by the arm model around the block. The grant is a one-cycle pulse, and the granted entry leaves the table on the same clock edge. The block does not model seek time, rotation or data transfer.

Top module: `disk_arm_sched`

## Requirements
- R1: After reset the table is empty, `grant_valid` is 0, `enq_full` is 0 and `dir_up` is 1 (increasing track numbers).
- R2: The table holds up to DEPTH (default 8) requests. `enq_full` is 1 exactly when all entries are occupied. An enqueue presented while `enq_full` is 1 is dropped and never granted.
- R3: A selection starts when `arm_ready` is sampled high at a rising edge, the table is non-empty and no selection is pending. `grant_valid` then rises for exactly one cycle after the following edge, and the granted entry is removed on that edge. `arm_ready` with an empty table produces no grant.
- R4: Policy code 0 grants the oldest pending request, whatever its track.
- R5: Policy code 1 grants the request whose track is nearest `head_track` (absolute distance). Equal distances go to the older request.
- R6: Policy code 2 grants the nearest request at or beyond the head in the current direction, where a track equal to the head counts as lying in either direction. When no request lies in that direction, the direction flips and the nearest request in the new direction is granted. Ties go to the older request.
- R7: Policy code 3 grants the nearest request with track >= head. If there is none, it grants the lowest pending track. `dir_up` is 1 after every grant under this policy. Ties go to the older request.
- R8: The policy is sampled only on the edge that starts a selection. A change on the following cycle does not affect that grant.
- R9: Grants under policy codes 0 and 1 leave `dir_up` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy | input | 2 | Selection policy: 0 arrival, 1 nearest, 2 elevator, 3 one-way wrap |
| head_track | input | TRACK_W (16) | Current head track |
| enq_valid | input | 1 | Enqueue strobe |
| enq_track | input | TRACK_W (16) | Track of the new request |
| enq_tag | input | TAG_W (4) | Tag of the new request |
| enq_full | output | 1 | All table entries occupied |
| arm_ready | input | 1 | Arm is free for the next request |
| grant_valid | output | 1 | One-cycle pulse: a grant is presented |
| grant_tag | output | TAG_W (4) | Tag of the granted request |
| grant_track | output | TRACK_W (16) | Track of the granted request |
| dir_up | output | 1 | Direction of travel, 1 means increasing tracks |

## Verification
Clustered track values make distance ties frequent. A design that ignored age on ties would return the younger of two equidistant requests. Directed cases cover an elevator sweep that runs out of requests ahead, where a design that failed to reverse would stall or grant behind the head without flipping `dir_up`. They also cover a one-way sweep past the highest request, where a faulty wrap would pick the nearest track below the head instead of the lowest. Further directed cases cover a request exactly at the head and a policy change in the cycle after `arm_ready`, which a design sampling late would serve under the wrong policy. Filling the table and then offering a ninth request checks that the extra request is never granted.

// File: rtl/arm_sched_pkg.sv
package arm_sched_pkg;
   typedef enum logic [1:0] {
      POL_FCFS  = 2'd0,
      POL_SSTF  = 2'd1,
      POL_SCAN  = 2'd2,
      POL_CSCAN = 2'd3
   } policy_e;
endpackage

// File: rtl/arm_req_table.sv
module arm_req_table #(
   parameter int DEPTH   = 8,
   parameter int TRACK_W = 16,
   parameter int TAG_W   = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [TRACK_W-1:0]              wr_track,
   input  logic [TAG_W-1:0]                wr_tag,
   input  logic                            clr_en,
   input  logic [$clog2(DEPTH)-1:0]        clr_idx,
   output logic [DEPTH-1:0]                valid_o,
   output logic [DEPTH-1:0][TRACK_W-1:0]   track_o,
   output logic [DEPTH-1:0][TAG_W-1:0]     tag_o,
   output logic [DEPTH-1:0][DEPTH-1:0]     older_o,
   output logic                            full_o
);
   localparam int IDX_W = $clog2(DEPTH);

   logic [DEPTH-1:0]              valid_q;
   logic [DEPTH-1:0][TRACK_W-1:0] track_q;
   logic [DEPTH-1:0][TAG_W-1:0]   tag_q;
   // older_q[i][j] set means entry i arrived before entry j
   logic [DEPTH-1:0][DEPTH-1:0]   older_q;
   logic [IDX_W-1:0]              free_idx;
   logic                          wr_ok;

   assign full_o  = &valid_q;
   assign wr_ok   = wr_en && !full_o;
   assign valid_o = valid_q;
   assign track_o = track_q;
   assign tag_o   = tag_q;
   assign older_o = older_q;

   // lowest free slot
   always_comb begin
      free_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!valid_q[i]) free_idx = IDX_W'(i);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         older_q <= '0;
         track_q <= '0;
         tag_q   <= '0;
      end else begin
         if (clr_en) valid_q[clr_idx] <= 1'b0;
         if (wr_ok) begin
            valid_q[free_idx] <= 1'b1;
            track_q[free_idx] <= wr_track;
            tag_q[free_idx]   <= wr_tag;
            for (int j = 0; j < DEPTH; j++) begin
               older_q[free_idx][j] <= 1'b0;
               if (IDX_W'(j) != free_idx) older_q[j][free_idx] <= valid_q[j];
            end
         end
      end
   end
endmodule

// File: rtl/arm_pick_min.sv
module arm_pick_min #(
   parameter int DEPTH = 8,
   parameter int KEY_W = 16
) (
   input  logic [DEPTH-1:0]              elig,
   input  logic [DEPTH-1:0][KEY_W-1:0]   key,
   input  logic [DEPTH-1:0][DEPTH-1:0]   older,
   output logic                          found,
   output logic [$clog2(DEPTH)-1:0]      idx
);
   localparam int IDX_W = $clog2(DEPTH);

   logic [KEY_W-1:0] best_key;

   always_comb begin
      found    = 1'b0;
      idx      = '0;
      best_key = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (elig[i] && (!found || key[i] < best_key ||
                         (key[i] == best_key && older[i][idx]))) begin
            found    = 1'b1;
            idx      = IDX_W'(i);
            best_key = key[i];
         end
      end
   end
endmodule

// File: rtl/disk_arm_sched.sv
module disk_arm_sched #(
   parameter int DEPTH   = 8,
   parameter int TRACK_W = 16,
   parameter int TAG_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         policy,
   input  logic [TRACK_W-1:0] head_track,
   input  logic               enq_valid,
   input  logic [TRACK_W-1:0] enq_track,
   input  logic [TAG_W-1:0]   enq_tag,
   output logic               enq_full,
   input  logic               arm_ready,
   output logic               grant_valid,
   output logic [TAG_W-1:0]   grant_tag,
   output logic [TRACK_W-1:0] grant_track,
   output logic               dir_up
);
   import arm_sched_pkg::*;

   localparam int IDX_W = $clog2(DEPTH);
   localparam int OCC_W = $clog2(DEPTH + 1);

   if (DEPTH < 2 || DEPTH > 64) begin : g_bad_depth
      $error("disk_arm_sched: DEPTH must lie in 2..64");
   end
   if (TRACK_W < 2 || TAG_W < 1) begin : g_bad_width
      $error("disk_arm_sched: TRACK_W >= 2 and TAG_W >= 1 required");
   end

   logic [DEPTH-1:0]              valid;
   logic [DEPTH-1:0][TRACK_W-1:0] trk;
   logic [DEPTH-1:0][TAG_W-1:0]   tag;
   logic [DEPTH-1:0][DEPTH-1:0]   older;
   logic                          full;

   logic                          pend_q;
   policy_e                       pol_q;
   logic                          dir_q;
   logic                          gv_q;
   logic [TAG_W-1:0]              gtag_q;
   logic [TRACK_W-1:0]            gtrk_q;

   logic                          start;
   logic [IDX_W-1:0]              sel_idx;
   logic                          sel_dir;
   logic [OCC_W-1:0]              occ;

   // per-entry eligibility and keys
   logic [DEPTH-1:0]              up_elig, dn_elig;
   logic [DEPTH-1:0][TRACK_W-1:0] near_key, up_key, dn_key, wrap_key;
   logic                          near_f, up_f, dn_f, wrap_f;
   logic [IDX_W-1:0]              near_i, up_i, dn_i, wrap_i;

   arm_req_table #(.DEPTH(DEPTH), .TRACK_W(TRACK_W), .TAG_W(TAG_W)) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (enq_valid),
      .wr_track (enq_track),
      .wr_tag   (enq_tag),
      .clr_en   (pend_q),
      .clr_idx  (sel_idx),
      .valid_o  (valid),
      .track_o  (trk),
      .tag_o    (tag),
      .older_o  (older),
      .full_o   (full)
   );

   for (genvar g = 0; g < DEPTH; g++) begin : g_key
      logic ahead, behind;
      assign ahead       = trk[g] >= head_track;
      assign behind      = trk[g] <= head_track;
      assign up_elig[g]  = valid[g] && ahead;
      assign dn_elig[g]  = valid[g] && behind;
      assign up_key[g]   = trk[g] - head_track;
      assign dn_key[g]   = head_track - trk[g];
      assign wrap_key[g] = trk[g];
      // arrival order uses a flat key so only age decides
      assign near_key[g] = (pol_q == POL_FCFS) ? '0 :
                           (ahead ? up_key[g] : dn_key[g]);
   end

   arm_pick_min #(.DEPTH(DEPTH), .KEY_W(TRACK_W)) u_pick_near (
      .elig(valid), .key(near_key), .older(older), .found(near_f), .idx(near_i));
   arm_pick_min #(.DEPTH(DEPTH), .KEY_W(TRACK_W)) u_pick_up (
      .elig(up_elig), .key(up_key), .older(older), .found(up_f), .idx(up_i));
   arm_pick_min #(.DEPTH(DEPTH), .KEY_W(TRACK_W)) u_pick_dn (
      .elig(dn_elig), .key(dn_key), .older(older), .found(dn_f), .idx(dn_i));
   arm_pick_min #(.DEPTH(DEPTH), .KEY_W(TRACK_W)) u_pick_wrap (
      .elig(valid), .key(wrap_key), .older(older), .found(wrap_f), .idx(wrap_i));

   always_comb begin
      sel_idx = near_i;
      sel_dir = dir_q;
      unique case (pol_q)
         POL_FCFS, POL_SSTF: begin
            sel_idx = near_i;
            sel_dir = dir_q;
         end
         POL_SCAN: begin
            if (dir_q) begin
               sel_idx = up_f ? up_i : dn_i;
               sel_dir = up_f;
            end else begin
               sel_idx = dn_f ? dn_i : up_i;
               sel_dir = !dn_f;
            end
         end
         POL_CSCAN: begin
            sel_idx = up_f ? up_i : wrap_i;
            sel_dir = 1'b1;
         end
         default: ;
      endcase
   end

   assign start = arm_ready && (|valid) && !pend_q;
   assign occ   = OCC_W'($countones(valid));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         pol_q  <= POL_FCFS;
         dir_q  <= 1'b1;
         gv_q   <= 1'b0;
         gtag_q <= '0;
         gtrk_q <= '0;
      end else begin
         pend_q <= start;
         gv_q   <= pend_q;
         if (start) pol_q <= policy_e'(policy);
         if (pend_q) begin
            gtag_q <= tag[sel_idx];
            gtrk_q <= trk[sel_idx];
            dir_q  <= sel_dir;
         end
      end
   end

   assign enq_full    = full;
   assign grant_valid = gv_q;
   assign grant_tag   = gtag_q;
   assign grant_track = gtrk_q;
   assign dir_up      = dir_q;
endmodule

// File: rtl/arm_sched_chk.sv
module arm_sched_chk #(
   parameter int DEPTH   = 8,
   parameter int TRACK_W = 16,
   parameter int OCC_W   = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               arm_ready,
   input logic               enq_valid,
   input logic               enq_full,
   input logic               grant_valid,
   input logic [TRACK_W-1:0] grant_track,
   input logic [TRACK_W-1:0] head_track,
   input logic               dir_up,
   input logic [1:0]         pol_q,
   input logic [OCC_W-1:0]   occ
);
   assert_grant_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |=> !grant_valid);

   assert_grant_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> $past(arm_ready, 2));

   assert_grant_removes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> (int'(occ) == int'($past(occ)) - 1 +
                       int'($past(enq_valid && !enq_full))));

   assert_full_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(enq_full) && !grant_valid |-> occ == $past(occ));

   assert_occ_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      int'(occ) <= DEPTH);

   assert_scan_ahead_R6: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid && pol_q == 2'd2 && dir_up && $past(dir_up)
      |-> grant_track >= $past(head_track));

   assert_wrap_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid && pol_q == 2'd3 |-> dir_up);

   assert_fixed_dir_R9: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid && pol_q[1] == 1'b0 |-> dir_up == $past(dir_up));
endmodule

bind disk_arm_sched arm_sched_chk #(
   .DEPTH(DEPTH), .TRACK_W(TRACK_W), .OCC_W($clog2(DEPTH + 1))
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .arm_ready   (arm_ready),
   .enq_valid   (enq_valid),
   .enq_full    (enq_full),
   .grant_valid (grant_valid),
   .grant_track (grant_track),
   .head_track  (head_track),
   .dir_up      (dir_up),
   .pol_q       (pol_q),
   .occ         (occ)
);

// File: tb/disk_arm_sched_tb_top.sv
module disk_arm_sched_tb_top;
   localparam int DEPTH = 8;
   localparam int TW    = 16;
   localparam int GW    = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    policy = 2'd0;
   logic [TW-1:0] head_track = '0;
   logic          enq_valid = 1'b0;
   logic [TW-1:0] enq_track = '0;
   logic [GW-1:0] enq_tag = '0;
   logic          enq_full;
   logic          arm_ready = 1'b0;
   logic          grant_valid;
   logic [GW-1:0] grant_tag;
   logic [TW-1:0] grant_track;
   logic          dir_up;

   always #2 clk = ~clk;

   disk_arm_sched #(.DEPTH(DEPTH), .TRACK_W(TW), .TAG_W(GW)) dut_i (
      .clk(clk), .rst_n(rst_n), .policy(policy), .head_track(head_track),
      .enq_valid(enq_valid), .enq_track(enq_track), .enq_tag(enq_tag),
      .enq_full(enq_full), .arm_ready(arm_ready), .grant_valid(grant_valid),
      .grant_tag(grant_tag), .grant_track(grant_track), .dir_up(dir_up));

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   // reference model
   bit m_v   [DEPTH];
   int m_trk [DEPTH];
   int m_tag [DEPTH];
   int m_seq [DEPTH];
   int m_next = 0;
   bit m_dir  = 1'b1;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int m_count();
      int c = 0;
      for (int i = 0; i < DEPTH; i++) if (m_v[i]) c++;
      return c;
   endfunction

   // mode 0: age only, 1: distance, 2: ahead (>=), 3: behind (<=), 4: lowest track
   function automatic int m_best(input int mode, input int head);
      int b = -1;
      int bk = 0;
      for (int i = 0; i < DEPTH; i++) begin
         int k;
         bit e;
         e = m_v[i];
         k = 0;
         case (mode)
            1: k = (m_trk[i] >= head) ? m_trk[i] - head : head - m_trk[i];
            2: begin e = e && (m_trk[i] >= head); k = m_trk[i] - head; end
            3: begin e = e && (m_trk[i] <= head); k = head - m_trk[i]; end
            4: k = m_trk[i];
            default: k = 0;
         endcase
         if (e && (b < 0 || k < bk || (k == bk && m_seq[i] < m_seq[b]))) begin
            b = i;
            bk = k;
         end
      end
      return b;
   endfunction

   function automatic string req_of(input int pol);
      case (pol)
         0: return "R4";
         1: return "R5";
         2: return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic enq(input int trk, input int tg);
      @(negedge clk);
      check(enq_full == (m_count() == DEPTH), "R2 full flag", enq_full, m_count() == DEPTH);
      enq_valid = 1'b1;
      enq_track = TW'(trk);
      enq_tag   = GW'(tg);
      if (m_count() < DEPTH) begin
         for (int i = 0; i < DEPTH; i++) begin
            if (!m_v[i]) begin
               m_v[i] = 1'b1; m_trk[i] = trk; m_tag[i] = tg; m_seq[i] = m_next++;
               break;
            end
         end
      end
      @(negedge clk);
      enq_valid = 1'b0;
   endtask

   // pol_late is driven on the cycle after arm_ready (R8)
   task automatic grant(input int pol, input int head, input int pol_late, input string extra);
      int idx;
      bit nd;
      string rq;
      @(negedge clk);
      policy = 2'(pol); head_track = TW'(head); arm_ready = 1'b1;
      @(negedge clk);
      arm_ready = 1'b0;
      policy = 2'(pol_late);
      nd = m_dir;
      case (pol)
         0: idx = m_best(0, head);
         1: idx = m_best(1, head);
         2: begin
            if (m_dir) begin
               idx = m_best(2, head);
               if (idx < 0) begin idx = m_best(3, head); nd = 1'b0; end
            end else begin
               idx = m_best(3, head);
               if (idx < 0) begin idx = m_best(2, head); nd = 1'b1; end
            end
         end
         default: begin
            idx = m_best(2, head);
            if (idx < 0) idx = m_best(4, head);
            nd = 1'b1;
         end
      endcase
      rq = {req_of(pol), extra};
      @(negedge clk);
      check(grant_valid == 1'b1, "R3 grant pulse", grant_valid, 1);
      if (idx >= 0) begin
         check(int'(grant_tag) == m_tag[idx], {rq, " tag"}, grant_tag, m_tag[idx]);
         check(int'(grant_track) == m_trk[idx], {rq, " track"}, grant_track, m_trk[idx]);
         m_v[idx] = 1'b0;
      end
      check(dir_up == nd, (pol < 2) ? "R9 dir" : {rq, " dir"}, dir_up, nd);
      m_dir = nd;
      @(negedge clk);
      check(grant_valid == 1'b0, "R3 single cycle", grant_valid, 0);
   endtask

   task automatic idle_ready();
      @(negedge clk);
      arm_ready = 1'b1;
      @(negedge clk);
      arm_ready = 1'b0;
      @(negedge clk);
      check(grant_valid == 1'b0, "R3 empty no grant", grant_valid, 0);
      @(negedge clk);
      check(grant_valid == 1'b0, "R3 empty no grant", grant_valid, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'd4711));
      for (int i = 0; i < DEPTH; i++) m_v[i] = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(grant_valid == 1'b0, "R1 grant", grant_valid, 0);
      check(enq_full == 1'b0, "R1 full", enq_full, 0);
      check(dir_up == 1'b1, "R1 dir", dir_up, 1);
      idle_ready();

      // R4 arrival order ignores distance
      enq(50, 1); enq(10, 2); enq(21, 3);
      grant(0, 20, 0, ""); grant(0, 20, 0, ""); grant(0, 20, 0, "");

      // R5 nearest with an equal-distance tie (12 and 20 from 16)
      enq(20, 4); enq(12, 5); enq(40, 6);
      grant(1, 16, 1, " tie"); grant(1, 16, 1, ""); grant(1, 16, 1, "");

      // R6 head-equal track, sweep up, then reversal
      enq(30, 7); enq(25, 8); enq(5, 9); enq(60, 10);
      grant(2, 25, 2, " equal"); grant(2, 25, 2, "");
      grant(2, 30, 2, ""); grant(2, 60, 2, " reverse");
      enq(70, 11);
      grant(2, 5, 2, " reverse up");

      // R7 wrap to the lowest pending track
      enq(15, 12); enq(8, 13); enq(90, 14);
      grant(3, 50, 3, ""); grant(3, 90, 3, " wrap"); grant(3, 8, 3, "");

      // R8 policy latched at start: arrival order, then switch to nearest
      enq(100, 1); enq(42, 2);
      grant(0, 40, 1, " R8 latch");
      grant(1, 40, 1, "");

      // R2 fill, refuse a ninth, drain
      for (int i = 0; i < DEPTH; i++) enq(200 + 3 * i, i);
      @(negedge clk);
      check(enq_full == 1'b1, "R2 full set", enq_full, 1);
      enq(7, 15);
      for (int i = 0; i < DEPTH; i++) grant(0, 0, 0, " R2 drain");
      idle_ready();

      // constrained random mix
      for (int it = 0; it < 600; it++) begin
         int r;
         r = $urandom_range(0, 99);
         if (r < 50 || m_count() == 0)
            enq($urandom_range(0, 40), $urandom_range(0, 15));
         else
            grant($urandom_range(0, 3), $urandom_range(0, 40), $urandom_range(0, 3), " rnd");
      end
      while (m_count() > 0) grant($urandom_range(0, 3), $urandom_range(0, 40), 0, " flush");
      idle_ready();

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule